// File: doc/BRIEF.md
# Dual-Input Reference Selection Controller

This controller runs in a free-running system clock domain and decides which of two reference inputs feeds a downstream PLL. Each input arrives with a raw loss indication that is already synchronous to the system clock. The block turns that indication into a sticky, qualified alarm per input. From the two alarms, a mode code and a manual pick line, it keeps a registered selection index. A switch-request pulse tells the clock multiplexer to move whenever that index changes.

There are three selection modes. In manual mode the block follows a debounced pick line. In the automatic modes it fails over to the healthy input on its own. The revertive variant returns to input 1 as soon as input 1 is healthy again. When both inputs are bad in an automatic mode, the block parks in a hold state and keeps the last good index. It leaves hold on whichever input qualifies first, and takes input 1 on a tie. A second code selects whether output 2 is enabled, disabled or driven in bypass. A global output enable stays low for as long as reset is held.

Top module: `clksel_ctrl`

## Requirements
- R1: With modeCode 0 (code 3 is treated the same), selIdx follows the debounced pick, where 0 selects input 1 and 1 selects input 2. selIdx updates one cycle after the debounced pick changes.
- R2: A new manSel level is accepted only after it has been sampled on STABLE_CYC consecutive clock edges. A shorter excursion leaves selIdx unchanged.
- R3: alarm[i] (bit 0 = input 1) is active high and sets on the edge that samples lossRaw[i]=1. It clears only on the VALID_CYC-th consecutive edge that samples lossRaw[i]=0. A single loss sample restarts the count.
- R4: With modeCode 1 (automatic, stay), selIdx keeps the current input while that input's alarm is clear. When that alarm sets, selIdx moves to the other input one cycle later, provided the other input is clear. It does not return when the first input recovers.
- R5: With modeCode 2 (automatic, return), selIdx is 0 in the cycle after any cycle in which alarm[0] is clear.
- R6: In an automatic mode, if both alarms are set, holdFlag rises one cycle later. selIdx then keeps the last active input, and no switch-request is raised.
- R7: Hold ends one cycle after the first alarm clears, and the block selects that input. If both alarms clear in the same cycle, it selects input 1.
- R8: switchReq is high for exactly the cycles in which selIdx differs from its value in the previous cycle.
- R9: activeOneHot is 2'b01 for input 1 and 2'b10 for input 2 when not in hold, and 2'b00 in hold.
- R10: out2Code is registered with one cycle of latency. Code 0 gives out2En=1 and bypassEn=0. Code 2 gives out2En=1 and bypassEn=1. Codes 1 and 3 give out2En=0 and bypassEn=0.
- R11: While rstN is low: outEn=0, selIdx=0, holdFlag=0, switchReq=0, alarm=2'b11, out2En=0, bypassEn=0. outEn goes to 1 on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lossRaw | input | 2 | Raw per-input loss indication, bit 0 = input 1 |
| modeCode | input | 2 | 0 manual, 1 automatic stay, 2 automatic return |
| manSel | input | 1 | Manual pick line, 0 = input 1 |
| out2Code | input | 2 | 0 enabled, 1 disabled, 2 bypass with output 2 enabled |
| selIdx | output | 1 | Selected input index, 0 = input 1 |
| activeOneHot | output | 2 | One-hot active input, zero in hold |
| holdFlag | output | 1 | Both inputs lost in an automatic mode |
| alarm | output | 2 | Sticky qualified alarms |
| switchReq | output | 1 | One-cycle pulse on a selection change |
| out2En | output | 1 | Output 2 enable |
| bypassEn | output | 1 | PLL bypass enable |
| outEn | output | 1 | Global output enable |

## Verification
The assertions take lossRaw, manSel and the two codes to be synchronous to clk and free of setup violations. No synchronizer sits in front of them, so a property such as "a loss sample sets the alarm on the next edge" depends on clean sampling. The stimulus changes every input only on the falling clock edge and holds it for whole cycles. This gives each rising edge a stable value. The bench also counts the edges exactly, so that the alarm run length and the debounce length can be checked at their boundary cycles.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  typedef enum logic [1:0] {
    SEL_MANUAL      = 2'd0,
    SEL_AUTO_STAY   = 2'd1,
    SEL_AUTO_RETURN = 2'd2,
    SEL_SPARE       = 2'd3
  } selMode_e;

  typedef enum logic [1:0] {
    OUT2_ON     = 2'd0,
    OUT2_OFF    = 2'd1,
    OUT2_BYPASS = 2'd2,
    OUT2_SPARE  = 2'd3
  } out2Mode_e;

  localparam int NUM_REF = 2;

  typedef struct packed {
    logic [NUM_REF-1:0] inValid;
    logic               manPick;
  } qualStrobes_t;
endpackage

// File: rtl/clksel_qualifier.sv
`timescale 1ns/1ps
module clksel_qualifier #(
  parameter int VALID_CYC = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic lossRaw,
  output logic alarm
);
  localparam int CW = $clog2(VALID_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(VALID_CYC - 1);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarm  <= 1'b1;
      runCnt <= '0;
    end else if (lossRaw) begin
      alarm  <= 1'b1;
      runCnt <= '0;
    end else if (alarm) begin
      if (runCnt == LAST) begin
        alarm  <= 1'b0;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  p_loss_sets_alarm_r3: assert property (@(posedge clk) disable iff (!rstN)
    lossRaw |=> alarm);
  p_clear_after_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarm) |-> (!$past(lossRaw) && !$past(lossRaw, 2)));
endmodule

// File: rtl/clksel_datapath.sv
`timescale 1ns/1ps
module clksel_datapath
  import clksel_pkg::*;
#(
  parameter int VALID_CYC  = 1024,
  parameter int STABLE_CYC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REF-1:0] lossRaw,
  input  logic               manSel,
  output logic [NUM_REF-1:0] alarm,
  output qualStrobes_t       strobes
);
  localparam int SW = $clog2(STABLE_CYC + 1);
  localparam logic [SW-1:0] S_LAST = SW'(STABLE_CYC - 1);

  for (genvar gi = 0; gi < NUM_REF; gi++) begin : g_ref
    clksel_qualifier #(.VALID_CYC(VALID_CYC)) u_qual (
      .clk    (clk),
      .rstN   (rstN),
      .lossRaw(lossRaw[gi]),
      .alarm  (alarm[gi])
    );
  end

  logic          manStable;
  logic [SW-1:0] pickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      manStable <= 1'b0;
      pickCnt   <= '0;
    end else if (manSel == manStable) begin
      pickCnt <= '0;
    end else if (pickCnt == S_LAST) begin
      manStable <= manSel;
      pickCnt   <= '0;
    end else begin
      pickCnt <= pickCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.inValid = ~alarm;
    strobes.manPick = manStable;
  end

  p_pick_from_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    (manStable != $past(manStable)) |-> (manStable == $past(manSel)));
endmodule

// File: rtl/clksel_control.sv
`timescale 1ns/1ps
module clksel_control
  import clksel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeCode,
  input  logic [1:0]         out2Code,
  input  qualStrobes_t       strobes,
  output logic               selIdx,
  output logic [NUM_REF-1:0] activeOneHot,
  output logic               holdFlag,
  output logic               switchReq,
  output logic               out2En,
  output logic               bypassEn,
  output logic               outEn
);
  selMode_e  modeNow;
  out2Mode_e out2Now;
  logic      nextSel, nextHold;
  logic      curOk;

  assign modeNow = selMode_e'(modeCode);
  assign out2Now = out2Mode_e'(out2Code);
  assign curOk   = strobes.inValid[selIdx];

  always_comb begin
    nextSel  = selIdx;
    nextHold = holdFlag;
    unique case (modeNow)
      SEL_AUTO_STAY, SEL_AUTO_RETURN: begin
        if (holdFlag) begin
          if (strobes.inValid[0]) begin
            nextSel = 1'b0; nextHold = 1'b0;
          end else if (strobes.inValid[1]) begin
            nextSel = 1'b1; nextHold = 1'b0;
          end
        end else if (strobes.inValid == '0) begin
          nextHold = 1'b1;
        end else if (modeNow == SEL_AUTO_RETURN && strobes.inValid[0]) begin
          nextSel = 1'b0;
        end else if (!curOk) begin
          nextSel = ~selIdx;
        end
      end
      default: begin
        nextSel  = strobes.manPick;
        nextHold = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx    <= 1'b0;
      holdFlag  <= 1'b0;
      switchReq <= 1'b0;
      out2En    <= 1'b0;
      bypassEn  <= 1'b0;
      outEn     <= 1'b0;
    end else begin
      selIdx    <= nextSel;
      holdFlag  <= nextHold;
      switchReq <= (nextSel != selIdx);
      out2En    <= (out2Now == OUT2_ON) || (out2Now == OUT2_BYPASS);
      bypassEn  <= (out2Now == OUT2_BYPASS);
      outEn     <= 1'b1;
    end
  end

  assign activeOneHot = holdFlag ? '0 : (selIdx ? 2'b10 : 2'b01);

  p_change_pulses_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selIdx != $past(selIdx)) |-> switchReq);
  p_pulse_means_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    switchReq |-> (selIdx != $past(selIdx)));
  p_hold_needs_both_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdFlag) |-> ($past(strobes.inValid) == 2'b00));
  p_hold_freezes_r6: assert property (@(posedge clk) disable iff (!rstN)
    (holdFlag && $past(holdFlag)) |-> $stable(selIdx));
  p_return_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeCode) == 2'd2 && $past(strobes.inValid[0])) |-> (!selIdx && !holdFlag));
  p_out2_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(out2Code) == 2'd1) |-> (!out2En && !bypassEn));
  p_oe_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(outEn) |-> outEn);
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int VALID_CYC  = 1024,
  parameter int STABLE_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lossRaw,
  input  logic [1:0] modeCode,
  input  logic       manSel,
  input  logic [1:0] out2Code,
  output logic       selIdx,
  output logic [1:0] activeOneHot,
  output logic       holdFlag,
  output logic [1:0] alarm,
  output logic       switchReq,
  output logic       out2En,
  output logic       bypassEn,
  output logic       outEn
);
  qualStrobes_t strobes;

  clksel_datapath #(.VALID_CYC(VALID_CYC), .STABLE_CYC(STABLE_CYC)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .lossRaw(lossRaw),
    .manSel (manSel),
    .alarm  (alarm),
    .strobes(strobes)
  );

  clksel_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .modeCode    (modeCode),
    .out2Code    (out2Code),
    .strobes     (strobes),
    .selIdx      (selIdx),
    .activeOneHot(activeOneHot),
    .holdFlag    (holdFlag),
    .switchReq   (switchReq),
    .out2En      (out2En),
    .bypassEn    (bypassEn),
    .outEn       (outEn)
  );
endmodule

// File: tb/sim_clksel_ctrl.sv
`timescale 1ns/1ps
module sim_clksel_ctrl;
  localparam int VC = 8;
  localparam int SC = 4;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] lossRaw, modeCode, out2Code;
  logic manSel;
  logic selIdx, holdFlag, switchReq, out2En, bypassEn, outEn;
  logic [1:0] activeOneHot, alarm;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  clksel_ctrl #(.VALID_CYC(VC), .STABLE_CYC(SC)) u0 (
    .clk(clk), .rstN(rstN), .lossRaw(lossRaw), .modeCode(modeCode),
    .manSel(manSel), .out2Code(out2Code), .selIdx(selIdx),
    .activeOneHot(activeOneHot), .holdFlag(holdFlag), .alarm(alarm),
    .switchReq(switchReq), .out2En(out2En), .bypassEn(bypassEn), .outEn(outEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rstN = 1'b0; lossRaw = 2'b11; modeCode = 2'd0; manSel = 1'b0; out2Code = 2'd1;
    tick(3);
    check("R11 outEn in reset", outEn, 0);
    check("R11 alarm in reset", alarm, 3);
    check("R11 selIdx in reset", selIdx, 0);
    check("R11 hold/switch in reset", {holdFlag, switchReq, out2En, bypassEn}, 0);
    rstN = 1'b1;
    tick(1);
    check("R11 outEn after release", outEn, 1);
  endtask

  task automatic t_alarm;
    lossRaw = 2'b10;
    tick(VC - 1);
    check("R3 alarm0 before run ends", alarm[0], 1);
    tick(1);
    check("R3 alarm0 clears at run end", alarm[0], 0);
    lossRaw = 2'b11;
    tick(1);
    check("R3 alarm0 sets on one loss sample", alarm[0], 1);
    lossRaw = 2'b10;
    tick(VC - 1);
    check("R3 run restarted after glitch", alarm[0], 1);
    tick(1);
    check("R3 alarm0 clears after full run", alarm[0], 0);
    lossRaw = 2'b00;
    tick(VC + 2);
    check("R3 alarm1 clears", alarm[1], 0);
  endtask

  task automatic t_manual;
    modeCode = 2'd0;
    manSel = 1'b1;
    tick(SC - 1);
    manSel = 1'b0;
    tick(3);
    check("R2 short pick ignored", selIdx, 0);
    manSel = 1'b1;
    tick(SC);
    check("R1 selIdx waits one cycle", selIdx, 0);
    tick(1);
    check("R1 selIdx follows pick", selIdx, 1);
    check("R8 pulse on change", switchReq, 1);
    tick(1);
    check("R8 pulse one cycle", switchReq, 0);
    check("R9 onehot input2", activeOneHot, 2);
  endtask

  task automatic t_stay;
    modeCode = 2'd1;
    tick(3);
    check("R4 stays on healthy input2", selIdx, 1);
    lossRaw = 2'b10;
    tick(1);
    check("R4 no move before alarm seen", selIdx, 1);
    tick(1);
    check("R4 fails over to input1", selIdx, 0);
    check("R8 pulse on failover", switchReq, 1);
    lossRaw = 2'b00;
    tick(VC + 4);
    check("R4 no return to input2", selIdx, 0);
    check("R9 onehot input1", activeOneHot, 1);
  endtask

  task automatic t_return;
    modeCode = 2'd1;
    lossRaw = 2'b01;
    tick(2);
    check("R4 failover to input2", selIdx, 1);
    lossRaw = 2'b00;
    tick(VC + 2);
    check("R4 stays input2 after recovery", selIdx, 1);
    modeCode = 2'd2;
    tick(1);
    check("R5 returns to input1", selIdx, 0);
    lossRaw = 2'b01;
    tick(2);
    check("R5 leaves failed input1", selIdx, 1);
    lossRaw = 2'b00;
    tick(VC);
    check("R5 waits for alarm clear", selIdx, 1);
    tick(1);
    check("R5 returns after clear", selIdx, 0);
  endtask

  task automatic t_hold;
    modeCode = 2'd1;
    lossRaw = 2'b01;
    tick(2);
    check("R4 on input2 before hold", selIdx, 1);
    lossRaw = 2'b11;
    tick(2);
    check("R6 hold entered", holdFlag, 1);
    check("R6 keeps last input", selIdx, 1);
    check("R9 onehot zero in hold", activeOneHot, 0);
    check("R6 no pulse into hold", switchReq, 0);
    lossRaw = 2'b00;
    tick(VC);
    check("R7 hold until alarm visible", holdFlag, 1);
    tick(1);
    check("R7 tie picks input1", {holdFlag, selIdx}, 0);
    lossRaw = 2'b11;
    tick(2);
    check("R6 hold again on input1", {holdFlag, selIdx}, 2);
    lossRaw = 2'b01;
    tick(VC + 1);
    check("R7 first valid input2 taken", {holdFlag, selIdx}, 1);
    check("R8 pulse leaving hold", switchReq, 1);
  endtask

  task automatic t_out2;
    for (int c = 0; c < 4; c++) begin
      out2Code = 2'(c);
      tick(1);
      check("R10 out2 decode", {out2En, bypassEn},
            (c == 0) ? 2 : (c == 2) ? 3 : 0);
    end
  endtask

  initial begin
    t_reset;
    t_alarm;
    t_manual;
    t_stay;
    t_return;
    t_hold;
    t_out2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule